// File: doc/BRIEF.md
# Channel-Enable Write Fan-Out

This block sits between a decoded host command stream and a set of per-channel register banks, four by default. It holds a persistent channel enable mask that a dedicated command loads. Every later register write goes out to all channels whose mask bit is set, in the same cycle. This gives single-channel, multi-channel and broadcast addressing without an address field for the channel.

A register read must resolve to exactly one channel. With one bit set, the block strobes that channel's read enable and returns its data one cycle later. With no bits or several bits set, no bank is strobed. In that case the response carries all-zero data and an error flag.

Commands arrive as a valid strobe plus a 2-bit opcode:
- 0 is a register write.
- 1 is a register read.
- 2 is a mask load.
- 3 is a no-op.

Top module: `chfan_top`

## Requirements
- R1: While rst_ni is low, en_mask_o is 0000 and ch_we_o, ch_re_o, rd_valid_o and rd_err_o are all zero.
- R2: A valid command with opcode 2 loads cmd_wdata_i[3:0] into en_mask_o at the next clock. Bit 0 maps to channel 1, bit 1 to channel 2, bit 2 to channel 3 and bit 3 to channel 4.
- R3: A mask-load command (opcode 2) asserts no bit of ch_we_o or ch_re_o.
- R4: A valid write (opcode 0) sets ch_we_o equal to en_mask_o in the same cycle. It drives cmd_addr_i and cmd_wdata_i unchanged onto ch_addr_o and ch_wdata_o.
- R5: With en_mask_o at 1111, a write asserts all four ch_we_o bits (broadcast).
- R6: With en_mask_o at 0000, a write asserts no ch_we_o bit and is ignored.
- R7: A valid read (opcode 1) with exactly one mask bit set asserts only that channel's ch_re_o bit in the same cycle. In the next cycle it gives rd_valid_o=1, rd_err_o=0, and rd_data_o equal to that channel's slice of ch_rdata_i (channel k at bits [16k+15:16k], k from 0) sampled in the read cycle.
- R8: A valid read with zero or more than one mask bit set asserts no ch_re_o bit. In the next cycle it gives rd_valid_o=1, rd_err_o=1 and rd_data_o=0; rd_valid_o and rd_err_o are high for that one cycle only unless the next command is again such a read.
- R9: A no-op (opcode 3), or any cycle with cmd_valid_i low, asserts no ch_we_o or ch_re_o bit and leaves en_mask_o unchanged.
- R10: en_mask_o keeps its value across all commands other than a mask load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 2 | Opcode: 0 write, 1 read, 2 mask load, 3 no-op |
| cmd_addr_i | input | 8 | Register address within a channel |
| cmd_wdata_i | input | 16 | Write data; bits [3:0] are the mask for opcode 2 |
| en_mask_o | output | 4 | Current channel enable mask |
| ch_we_o | output | 4 | Per-channel write enable |
| ch_re_o | output | 4 | Per-channel read enable, at most one set |
| ch_addr_o | output | 8 | Register address to the banks |
| ch_wdata_o | output | 16 | Write data to the banks |
| ch_rdata_i | input | 64 | Read data from the banks, 16 bits per channel |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | 16 | Read response data |
| rd_err_o | output | 1 | Read selection was ambiguous or empty |

## Verification
The assertions assume that the banks present ch_rdata_i combinationally for the address on ch_addr_o. They also assume the opcode is meaningful only while cmd_valid_i is high.

The bench models each bank as a fixed function of channel number and address. This keeps every read result predictable and distinct per channel. The stimulus holds commands stable for a full cycle and walks all sixteen mask values, so broadcast, empty, single-channel and multi-channel selections are all covered for both writes and reads.

// File: rtl/chfan_pkg.sv
package chfan_pkg;
  typedef enum logic [1:0] {
    OP_REG_WR = 2'd0,
    OP_REG_RD = 2'd1,
    OP_EN_WR  = 2'd2,
    OP_NOP    = 2'd3
  } chfan_op_e;
endpackage

// File: rtl/chfan_enable_reg.sv
module chfan_enable_reg #(
  parameter int NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [NCH-1:0] val_i,
  output logic [NCH-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_o <= '0;
    else if (load_i) mask_o <= val_i;
  end
endmodule

// File: rtl/chfan_write_fanout.sv
module chfan_write_fanout #(
  parameter int NCH = 4
) (
  input  logic           wr_i,
  input  logic [NCH-1:0] mask_i,
  output logic [NCH-1:0] we_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_we
    assign we_o[g] = wr_i & mask_i[g];
  end
endmodule

// File: rtl/chfan_read_select.sv
module chfan_read_select #(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_i,
  input  logic [NCH-1:0]  mask_i,
  input  logic [NCH*DW-1:0] rdata_i,
  output logic [NCH-1:0]  re_o,
  output logic            rd_valid_o,
  output logic [DW-1:0]   rd_data_o,
  output logic            rd_err_o
);
  localparam int CW = $clog2(NCH + 1);

  logic [CW-1:0] nsel;
  logic          single;
  logic [DW-1:0] mux;

  always_comb begin
    nsel = '0;
    for (int i = 0; i < NCH; i++) nsel = nsel + CW'(mask_i[i]);
  end
  assign single = (nsel == CW'(1));
  assign re_o   = (rd_i && single) ? mask_i : '0;

  // AND-OR mux; valid because re_o is one-hot or zero
  always_comb begin
    mux = '0;
    for (int i = 0; i < NCH; i++)
      if (re_o[i]) mux = mux | rdata_i[i*DW +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_err_o   <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_i;
      rd_err_o   <= rd_i & ~single;
      rd_data_o  <= rd_i ? mux : '0;
    end
  end
endmodule

// File: rtl/chfan_top.sv
module chfan_top
  import chfan_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int DW  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [AW-1:0]     cmd_addr_i,
  input  logic [DW-1:0]     cmd_wdata_i,
  output logic [NCH-1:0]    en_mask_o,
  output logic [NCH-1:0]    ch_we_o,
  output logic [NCH-1:0]    ch_re_o,
  output logic [AW-1:0]     ch_addr_o,
  output logic [DW-1:0]     ch_wdata_o,
  input  logic [NCH*DW-1:0] ch_rdata_i,
  output logic              rd_valid_o,
  output logic [DW-1:0]     rd_data_o,
  output logic              rd_err_o
);
  chfan_op_e op;
  logic      do_wr, do_rd, do_en;

  assign op    = chfan_op_e'(cmd_op_i);
  assign do_wr = cmd_valid_i && (op == OP_REG_WR);
  assign do_rd = cmd_valid_i && (op == OP_REG_RD);
  assign do_en = cmd_valid_i && (op == OP_EN_WR);

  assign ch_addr_o  = cmd_addr_i;
  assign ch_wdata_o = cmd_wdata_i;

  chfan_enable_reg #(.NCH(NCH)) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (do_en),
    .val_i  (cmd_wdata_i[NCH-1:0]),
    .mask_o (en_mask_o)
  );

  chfan_write_fanout #(.NCH(NCH)) u_wr (
    .wr_i   (do_wr),
    .mask_i (en_mask_o),
    .we_o   (ch_we_o)
  );

  chfan_read_select #(.NCH(NCH), .DW(DW)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (do_rd),
    .mask_i     (en_mask_o),
    .rdata_i    (ch_rdata_i),
    .re_o       (ch_re_o),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .rd_err_o   (rd_err_o)
  );
endmodule

// File: rtl/chfan_checks.sv
module chfan_checks #(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cmd_valid_i,
  input logic [1:0]     cmd_op_i,
  input logic [DW-1:0]  cmd_wdata_i,
  input logic [NCH-1:0] en_mask_o,
  input logic [NCH-1:0] ch_we_o,
  input logic [NCH-1:0] ch_re_o,
  input logic           rd_valid_o,
  input logic [DW-1:0]  rd_data_o,
  input logic           rd_err_o
);
  a_r2_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd2) |=> en_mask_o == $past(cmd_wdata_i[NCH-1:0]));

  a_r10_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && cmd_op_i == 2'd2) |=> $stable(en_mask_o));

  a_r3_en_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd2) |-> (ch_we_o == '0 && ch_re_o == '0));

  a_r4_we_in_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_we_o & ~en_mask_o) == '0);

  a_r7_re_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_re_o));

  a_r7_single_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd1 && $countones(en_mask_o) == 1) |=> (rd_valid_o && !rd_err_o));

  a_r8_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> (rd_valid_o && rd_data_o == '0));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_valid_i || cmd_op_i == 2'd3) |-> (ch_we_o == '0 && ch_re_o == '0));
endmodule

bind chfan_top chfan_checks #(.NCH(NCH), .DW(DW)) u_chfan_checks (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .cmd_wdata_i (cmd_wdata_i),
  .en_mask_o   (en_mask_o),
  .ch_we_o     (ch_we_o),
  .ch_re_o     (ch_re_o),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .rd_err_o    (rd_err_o)
);

// File: tb/chfan_top_test.sv
module chfan_top_test;
  localparam int NCH = 4;
  localparam int AW  = 8;
  localparam int DW  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [1:0]        cmd_op = 2'd3;
  logic [AW-1:0]     cmd_addr = '0;
  logic [DW-1:0]     cmd_wdata = '0;
  logic [NCH-1:0]    en_mask, ch_we, ch_re;
  logic [AW-1:0]     ch_addr;
  logic [DW-1:0]     ch_wdata, rd_data;
  logic [NCH*DW-1:0] ch_rdata;
  logic              rd_valid, rd_err;

  int checks = 0;
  int errors = 0;

  // Model state
  logic [NCH-1:0] m_mask = '0, m_mask_n = '0;
  logic           e_valid = 0, e_err = 0, n_valid = 0, n_err = 0;
  logic [DW-1:0]  e_data = '0, n_data = '0;

  always #2 clk = ~clk;

  chfan_top #(.NCH(NCH), .AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .en_mask_o(en_mask),
    .ch_we_o(ch_we), .ch_re_o(ch_re), .ch_addr_o(ch_addr), .ch_wdata_o(ch_wdata),
    .ch_rdata_i(ch_rdata), .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_err_o(rd_err)
  );

  function automatic logic [DW-1:0] bank_val(int ch, logic [AW-1:0] a);
    return {4'hA, a, 4'(ch + 1)};
  endfunction

  always_comb
    for (int i = 0; i < NCH; i++) ch_rdata[i*DW +: DW] = bank_val(i, ch_addr);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic v, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
    logic [NCH-1:0] exp_we, exp_re;
    int n;
    string tw, tr;
    @(posedge clk);
    m_mask  = m_mask_n;
    e_valid = n_valid; e_err = n_err; e_data = n_data;
    #1;
    cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    n = $countones(m_mask);
    exp_we = (v && op == 2'd0) ? m_mask : '0;
    exp_re = (v && op == 2'd1 && n == 1) ? m_mask : '0;
    if (v && op == 2'd2)      tw = "R3";
    else if (!v || op == 2'd3) tw = "R9";
    else if (m_mask == '1)     tw = "R5";
    else if (m_mask == '0)     tw = "R6";
    else                       tw = "R4";
    tr = (e_err) ? "R8" : "R7";
    chk("R10", 32'(en_mask), 32'(m_mask), "en_mask");
    chk(tw, 32'(ch_we), 32'(exp_we), "ch_we");
    chk((v && op == 2'd2) ? "R3" : "R7", 32'(ch_re), 32'(exp_re), "ch_re");
    chk("R4", 32'(ch_addr), 32'(a), "ch_addr");
    chk("R4", 32'(ch_wdata), 32'(d), "ch_wdata");
    chk(tr, 32'(rd_valid), 32'(e_valid), "rd_valid");
    chk(tr, 32'(rd_err), 32'(e_err), "rd_err");
    chk(tr, 32'(rd_data), 32'(e_data), "rd_data");
    // next-state of model
    m_mask_n = (v && op == 2'd2) ? d[NCH-1:0] : m_mask;
    n_valid = v && op == 2'd1;
    n_err   = n_valid && n != 1;
    n_data  = '0;
    if (n_valid && n == 1)
      for (int i = 0; i < NCH; i++) if (m_mask[i]) n_data = bank_val(i, a);
  endtask

  task automatic en_load(logic [NCH-1:0] m);
    step(1'b1, 2'd2, 8'h00, {12'h5A5, m});
    step(1'b1, 2'd3, 8'h00, 16'h0);
    chk("R2", 32'(en_mask), 32'(m), "en_mask after load");
  endtask

  initial begin : watchdog
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3;
    @(negedge clk);
    chk("R1", 32'(en_mask), 0, "en_mask in reset");
    chk("R1", 32'(ch_we), 0, "ch_we in reset");
    chk("R1", 32'(ch_re), 0, "ch_re in reset");
    chk("R1", 32'(rd_valid), 0, "rd_valid in reset");
    chk("R1", 32'(rd_err), 0, "rd_err in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // empty mask: write ignored, read errors
    step(1'b1, 2'd0, 8'h11, 16'hBEEF);
    step(1'b1, 2'd1, 8'h12, 16'h0);
    step(1'b1, 2'd1, 8'h13, 16'h0);
    step(1'b0, 2'd0, 8'h14, 16'h1234);

    // every mask value: write, read, idle, invalid-strobe load attempt
    for (int m = 0; m < 16; m++) begin
      en_load(4'(m));
      step(1'b1, 2'd0, 8'(m * 7), 16'(m * 16'h0101));
      step(1'b1, 2'd1, 8'(m + 8'h40), 16'h0);
      step(1'b0, 2'd2, 8'h00, 16'h000F);
      step(1'b1, 2'd3, 8'h00, 16'h0000);
      chk("R10", 32'(en_mask), 32'(m), "mask held");
    end

    // broadcast then single-channel reads back to back
    en_load(4'hF);
    step(1'b1, 2'd0, 8'hFF, 16'hCAFE);
    for (int c = 0; c < NCH; c++) begin
      step(1'b1, 2'd2, 8'h00, 16'(1 << c));
      step(1'b1, 2'd1, 8'(c + 8'h80), 16'h0);
      step(1'b1, 2'd1, 8'(c + 8'h90), 16'h0);
    end
    step(1'b1, 2'd3, 8'h00, 16'h0);
    step(1'b1, 2'd3, 8'h00, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule